// File: doc/BRIEF.md
# Set-associative data TLB translator

This block turns a virtual data address into a physical address. It uses a small TLB with a parameter-chosen number of ways, from one to four. Each way keeps one entry per set. The set is picked by the address bits just above the page offset. An entry has two halves. The match half holds a virtual page tag and a valid bit. The translate half holds a physical page number, a cache-inhibit flag and four access-permission flags. Software, or a refill engine outside this block, loads entries through a plain register-write port. The block never refills itself.

A lookup request carries the address and four flags: write, supervisor mode, probe, and through-data-cache. One cycle later the block returns a response strobe with the result:
- the physical address;
- a cache-inhibit level;
- a hit flag;
- at most one exception, either a TLB miss or a page fault, together with the faulting virtual address.

When translation is switched off, or the block is built as not present, the address passes through unchanged and cache inhibit follows the top address bit. A probe lookup asks whether a translation exists and is allowed, with no side effects. It never raises an exception, and it changes the cache-inhibit output only when it is marked as going through the data cache.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset every entry is invalid and all response outputs (strobe, address, cache inhibit, hit, both exceptions, exception address) are zero.
- R2: A request accepted on a clock edge gives a response strobe of exactly one cycle after that edge. The other response outputs change only on request cycles. Without a request they keep their values.
- R3: With xlat_en low, or with PRESENT=0, the response address equals the request address. Hit and both exceptions are 0. Cache inhibit becomes the top address bit (1 for addresses at or above 2^(AW-1)), except for a probe without through-data-cache, which leaves cache inhibit unchanged.
- R4: The set index is address bits [PAGE_LOG2 +: log2(NSETS)]. An entry written to set s and way w is seen only by lookups whose index is s.
- R5: A way hits when its valid bit is 1 and its stored tag equals address bits [AW-1 : PAGE_LOG2+log2(NSETS)]. A match-half write (wr_sel=0) takes the tag from those same wr_data bits and the valid bit from wr_data[0].
- R6: On a hit, the physical address is the translate entry's bits [AW-1:PAGE_LOG2] above the request address bits [PAGE_LOG2-1:0]. A translate-half write (wr_sel=1) takes the page number from wr_data[AW-1:PAGE_LOG2].
- R7: When several ways hit, the lowest-numbered way supplies the translation.
- R8: The translate flags are wr_data[1] user read, [2] user write, [3] supervisor read and [4] supervisor write. The flag needed depends on the supervisor and write inputs. On a non-probe hit whose needed flag is 0, the page-fault output is raised, the exception address is the virtual address, and the physical address is still the translated one.
- R9: On a non-probe hit, cache inhibit becomes the entry's cache-inhibit flag, wr_data[0] of the translate write.
- R10: A non-probe miss raises the miss output, returns physical address 0 and hit 0, puts the virtual address on the exception address, and leaves cache inhibit unchanged. Whenever no exception is raised, the exception address is 0.
- R11: A probe raises no exception. A probe miss, or a probe hit without permission, returns address 0 and leaves cache inhibit unchanged. A permitted probe hit returns the translation and updates cache inhibit only when req_thru_dc is 1.
- R12: An entry whose valid bit is 0 never hits, even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | AW (32) | Virtual address |
| req_write | input | 1 | Access is a write |
| req_super | input | 1 | Access is in supervisor mode |
| req_probe | input | 1 | Side-effect-free probe lookup |
| req_thru_dc | input | 1 | Probe goes through the data cache |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | WAY_W (1) | Way to write; values at or above NWAYS are ignored |
| wr_sel | input | 1 | 0 writes the match half, 1 the translate half |
| wr_set | input | log2(NSETS) (4) | Set to write |
| wr_data | input | AW (32) | Entry contents |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | AW (32) | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_hit | output | 1 | A valid way matched in translating mode |
| rsp_miss_exc | output | 1 | TLB miss exception |
| rsp_fault_exc | output | 1 | Page fault exception |
| rsp_exc_addr | output | AW (32) | Virtual address of the exception, else 0 |

## Verification
The bench places two ways of one set on the same tag and then invalidates the first. A design with the wrong search order, or one that ignores the valid bit, returns the other way's page number. It probes an entry that carries cache inhibit but no permission right after a bypass has cleared cache inhibit. A design that updates cache inhibit before it checks the permission, or that lets a probe raise an exception, shows a wrong level or a spurious fault. It reuses one tag at the neighbouring set index to catch a wrong set slice. It also covers each supervisor and user, read and write combination, because swapping two permission flags would fault on an allowed access. A long randomized run with writes landing in the same cycle as lookups then confirms that a lookup sees the table as it was before the write.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

   // Translate-half flag layout; the packed order fixes wr_data[4:0]
   typedef struct packed {
      logic sup_wr;
      logic sup_rd;
      logic usr_wr;
      logic usr_rd;
      logic cinh;
   } dtlb_flags_t;

   localparam int unsigned FLAG_W = $bits(dtlb_flags_t);

   localparam logic SEL_MATCH = 1'b0;
   localparam logic SEL_XLATE = 1'b1;

endpackage

// File: rtl/dtlb_perm.sv
module dtlb_perm
   import dtlb_pkg::*;
(
   input  dtlb_flags_t flags,
   input  logic        is_write,
   input  logic        is_super,
   output logic        allowed
);

   always_comb begin
      unique case ({is_super, is_write})
         2'b00:   allowed = flags.usr_rd;
         2'b01:   allowed = flags.usr_wr;
         2'b10:   allowed = flags.sup_rd;
         default: allowed = flags.sup_wr;
      endcase
   end

endmodule

// File: rtl/dtlb_way.sv
module dtlb_way
   import dtlb_pkg::*;
#(
   parameter int unsigned NSETS  = 16,
   parameter int unsigned TAG_W  = 15,
   parameter int unsigned PPN_W  = 19,
   localparam int unsigned SET_W = $clog2(NSETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_vld,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  dtlb_flags_t       wr_flags,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic [PPN_W-1:0]  rd_ppn,
   output dtlb_flags_t       rd_flags
);

   logic [NSETS-1:0] vld_q;
   logic [TAG_W-1:0] tag_q   [NSETS];
   logic [PPN_W-1:0] ppn_q   [NSETS];
   dtlb_flags_t      flags_q [NSETS];

   // only the valid bits need a reset value
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en && wr_sel == SEL_MATCH) begin
         vld_q[wr_set] <= wr_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (wr_sel == SEL_MATCH) begin
            tag_q[wr_set] <= wr_tag;
         end else begin
            ppn_q[wr_set]   <= wr_ppn;
            flags_q[wr_set] <= wr_flags;
         end
      end
   end

   assign rd_hit   = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
   assign rd_ppn   = ppn_q[rd_set];
   assign rd_flags = flags_q[rd_set];

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
   import dtlb_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned PAGE_LOG2 = 13,
   parameter int unsigned NSETS     = 16,
   parameter int unsigned NWAYS     = 2,
   parameter bit          PRESENT   = 1'b1,
   localparam int unsigned SET_W    = $clog2(NSETS),
   localparam int unsigned WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xlat_en,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_write,
   input  logic             req_super,
   input  logic             req_probe,
   input  logic             req_thru_dc,
   input  logic             wr_en,
   input  logic [WAY_W-1:0] wr_way,
   input  logic             wr_sel,
   input  logic [SET_W-1:0] wr_set,
   input  logic [AW-1:0]    wr_data,
   output logic             rsp_valid,
   output logic [AW-1:0]    rsp_paddr,
   output logic             rsp_ci,
   output logic             rsp_hit,
   output logic             rsp_miss_exc,
   output logic             rsp_fault_exc,
   output logic [AW-1:0]    rsp_exc_addr
);

   localparam int unsigned TAG_LO = PAGE_LOG2 + SET_W;
   localparam int unsigned TAG_W  = AW - TAG_LO;
   localparam int unsigned PPN_W  = AW - PAGE_LOG2;

   // ---------------- elaboration checks ----------------
   if (NWAYS < 1 || NWAYS > 4) begin : g_bad_ways
      $error("dtlb_xlate: NWAYS must lie in 1..4");
   end
   if (NSETS < 2 || NSETS > 256 || (NSETS & (NSETS - 1)) != 0) begin : g_bad_sets
      $error("dtlb_xlate: NSETS must be a power of two in 2..256");
   end
   if (PAGE_LOG2 < FLAG_W + 1 || TAG_LO >= AW) begin : g_bad_page
      $error("dtlb_xlate: PAGE_LOG2 leaves no room for flags or tag");
   end

   // ---------------- request fields ----------------
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [PAGE_LOG2-1:0] lk_off;
   assign lk_set = req_addr[PAGE_LOG2 +: SET_W];
   assign lk_tag = req_addr[AW-1:TAG_LO];
   assign lk_off = req_addr[PAGE_LOG2-1:0];

   // bits of wr_data that neither entry half keeps
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[PAGE_LOG2-1:FLAG_W];

   // ---------------- way array ----------------
   logic [NWAYS-1:0] way_hit;
   logic [PPN_W-1:0] way_ppn   [NWAYS];
   dtlb_flags_t      way_flags [NWAYS];

   for (genvar g = 0; g < NWAYS; g++) begin : g_way
      logic way_wr;
      assign way_wr = wr_en && (wr_way == WAY_W'(g));
      dtlb_way #(
         .NSETS (NSETS),
         .TAG_W (TAG_W),
         .PPN_W (PPN_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (way_wr),
         .wr_sel   (wr_sel),
         .wr_set   (wr_set),
         .wr_tag   (wr_data[AW-1:TAG_LO]),
         .wr_vld   (wr_data[0]),
         .wr_ppn   (wr_data[AW-1:PAGE_LOG2]),
         .wr_flags (dtlb_flags_t'(wr_data[FLAG_W-1:0])),
         .rd_set   (lk_set),
         .rd_tag   (lk_tag),
         .rd_hit   (way_hit[g]),
         .rd_ppn   (way_ppn[g]),
         .rd_flags (way_flags[g])
      );
   end

   // ---------------- first-way priority pick ----------------
   logic             sel_hit;
   logic [PPN_W-1:0] sel_ppn;
   dtlb_flags_t      sel_flags;

   always_comb begin
      sel_hit   = 1'b0;
      sel_ppn   = '0;
      sel_flags = '0;
      for (int w = NWAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) begin
            sel_hit   = 1'b1;
            sel_ppn   = way_ppn[w];
            sel_flags = way_flags[w];
         end
      end
   end

   logic perm_ok;
   dtlb_perm u_perm (
      .flags    (sel_flags),
      .is_write (req_write),
      .is_super (req_super),
      .allowed  (perm_ok)
   );

   // ---------------- translation active select ----------------
   logic active;
   if (PRESENT) begin : g_present
      assign active = xlat_en;
   end else begin : g_absent
      logic unused_xlat_en;
      assign unused_xlat_en = xlat_en;
      assign active = 1'b0;
   end

   // ---------------- next response ----------------
   logic [AW-1:0] nx_paddr;
   logic [AW-1:0] nx_exc_addr;
   logic [AW-1:0] xl_addr;
   logic          nx_hit;
   logic          nx_miss;
   logic          nx_fault;
   logic          nx_ci_upd;
   logic          nx_ci;

   assign xl_addr = {sel_ppn, lk_off};

   always_comb begin
      nx_paddr    = '0;
      nx_exc_addr = '0;
      nx_hit      = 1'b0;
      nx_miss     = 1'b0;
      nx_fault    = 1'b0;
      nx_ci_upd   = 1'b0;
      nx_ci       = 1'b0;
      if (!active) begin
         nx_paddr  = req_addr;
         nx_ci     = req_addr[AW-1];
         nx_ci_upd = !req_probe || req_thru_dc;
      end else if (sel_hit) begin
         nx_hit = 1'b1;
         nx_ci  = sel_flags.cinh;
         if (req_probe) begin
            nx_paddr  = perm_ok ? xl_addr : '0;
            nx_ci_upd = perm_ok && req_thru_dc;
         end else begin
            nx_paddr    = xl_addr;
            nx_ci_upd   = 1'b1;
            nx_fault    = !perm_ok;
            nx_exc_addr = perm_ok ? '0 : req_addr;
         end
      end else begin
         nx_miss     = !req_probe;
         nx_exc_addr = req_probe ? '0 : req_addr;
      end
   end

   // ---------------- response registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_hit       <= 1'b0;
         rsp_miss_exc  <= 1'b0;
         rsp_fault_exc <= 1'b0;
         rsp_exc_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr     <= nx_paddr;
            rsp_hit       <= nx_hit;
            rsp_miss_exc  <= nx_miss;
            rsp_fault_exc <= nx_fault;
            rsp_exc_addr  <= nx_exc_addr;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_ci <= 1'b0;
      end else if (req_valid && nx_ci_upd) begin
         rsp_ci <= nx_ci;
      end
   end

   // ---------------- assertions ----------------
   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_bypass_passes_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlat_en) |=> (rsp_paddr == $past(req_addr)) && !rsp_hit
                                  && !rsp_miss_exc && !rsp_fault_exc);

   assert_exc_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_miss_exc && rsp_fault_exc));

   assert_miss_returns_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss_exc |-> (rsp_paddr == '0) && !rsp_hit);

   assert_probe_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_probe) |=> !rsp_miss_exc && !rsp_fault_exc);

endmodule

// File: tb/dtlb_xlate_bench.sv
`timescale 1ns/1ps
module dtlb_xlate_bench;

   localparam int NW   = 3;
   localparam int NS   = 16;
   localparam int PGL  = 13;
   localparam logic [31:0] OFFMASK = 32'h0000_1FFF;
   localparam logic [31:0] TAGMASK = 32'hFFFE_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_super = 1'b0;
   logic        req_probe = 1'b0;
   logic        req_thru_dc = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_way = '0;
   logic        wr_sel = 1'b0;
   logic [3:0]  wr_set = '0;
   logic [31:0] wr_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_ci;
   logic        rsp_hit;
   logic        rsp_miss_exc;
   logic        rsp_fault_exc;
   logic [31:0] rsp_exc_addr;

   always #4 clk = ~clk;

   dtlb_xlate #(
      .AW(32), .PAGE_LOG2(PGL), .NSETS(NS), .NWAYS(NW), .PRESENT(1'b1)
   ) u_dtlb_xlate (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_super(req_super), .req_probe(req_probe), .req_thru_dc(req_thru_dc),
      .wr_en(wr_en), .wr_way(wr_way), .wr_sel(wr_sel), .wr_set(wr_set),
      .wr_data(wr_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
      .rsp_hit(rsp_hit), .rsp_miss_exc(rsp_miss_exc),
      .rsp_fault_exc(rsp_fault_exc), .rsp_exc_addr(rsp_exc_addr)
   );

   integer n_checks = 0;
   integer n_fails  = 0;
   bit     compare_on = 1'b0;
   bit     finished = 1'b0;

   // ---------------- reference model ----------------
   logic [31:0] m_match [4][NS];
   logic [31:0] m_trans [4][NS];
   logic        e_valid, e_ci, e_hit, e_miss, e_fault;
   logic [31:0] e_paddr, e_exc;
   string       e_tag = "R1";

   task automatic model_lookup();
      logic [31:0] a;
      logic [31:0] fl;
      int          s;
      int          hw;
      bit          ok;
      a  = req_addr;
      s  = int'((a >> PGL) & 32'd15);
      hw = -1;
      e_miss = 1'b0; e_fault = 1'b0; e_exc = '0; e_hit = 1'b0; e_paddr = '0;
      if (!xlat_en) begin
         e_paddr = a;
         if (!req_probe || req_thru_dc) e_ci = a[31];
         e_tag = "R3";
      end else begin
         for (int w = 0; w < NW; w++)
            if (hw < 0 && m_match[w][s][0] && (((m_match[w][s] ^ a) & TAGMASK) == 0))
               hw = w;
         if (hw >= 0) begin
            fl = m_trans[hw][s];
            if (req_super) ok = req_write ? fl[4] : fl[3];
            else           ok = req_write ? fl[2] : fl[1];
            e_hit = 1'b1;
            if (req_probe) begin
               e_tag = "R11";
               if (ok) begin
                  e_paddr = (fl & ~OFFMASK) | (a & OFFMASK);
                  if (req_thru_dc) e_ci = fl[0];
               end
            end else begin
               e_tag   = ok ? "R6" : "R8";
               e_paddr = (fl & ~OFFMASK) | (a & OFFMASK);
               e_ci    = fl[0];
               e_fault = !ok;
               e_exc   = ok ? 32'h0 : a;
            end
         end else begin
            e_tag  = req_probe ? "R11" : "R10";
            e_miss = !req_probe;
            e_exc  = req_probe ? 32'h0 : a;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_ci = 0; e_hit = 0; e_miss = 0; e_fault = 0;
         e_paddr = '0; e_exc = '0; e_tag = "R1";
         for (int w = 0; w < 4; w++)
            for (int s = 0; s < NS; s++) m_match[w][s] = '0;
      end else begin
         e_valid = req_valid;
         if (req_valid) model_lookup();
         else e_tag = "R2";
         if (wr_en && int'(wr_way) < NW) begin
            if (wr_sel) m_trans[wr_way][wr_set] = wr_data;
            else        m_match[wr_way][wr_set] = wr_data;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && compare_on && !finished) begin
         n_checks++;
         if ({rsp_valid, rsp_ci, rsp_hit, rsp_miss_exc, rsp_fault_exc, rsp_paddr, rsp_exc_addr}
             !== {e_valid, e_ci, e_hit, e_miss, e_fault, e_paddr, e_exc}) begin
            n_fails++;
            $display("FAIL %s cycle: act v=%b ci=%b hit=%b miss=%b flt=%b pa=%h ea=%h exp v=%b ci=%b hit=%b miss=%b flt=%b pa=%h ea=%h",
                     e_tag, rsp_valid, rsp_ci, rsp_hit, rsp_miss_exc, rsp_fault_exc,
                     rsp_paddr, rsp_exc_addr, e_valid, e_ci, e_hit, e_miss, e_fault,
                     e_paddr, e_exc);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic lookup(input logic [31:0] a, input bit wr, input bit sup,
                         input bit prb, input bit thru);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_super = sup;
      req_probe = prb; req_thru_dc = thru;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic put(input int way, input int set, input bit sel, input logic [31:0] d);
      wr_en = 1'b1; wr_way = 2'(way); wr_set = 4'(set); wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic void summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
   endfunction

   // watchdog
   integer cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: act %0d cycles exp completion", cyc);
         summary();
         $finish;
      end
   end

   localparam logic [31:0] VA = 32'h0246_6ABC;   // set 3, tag 0x123, offset 0xABC

   logic [14:0] pool [4];

   initial begin
      pool[0] = 15'h0123; pool[1] = 15'h0124; pool[2] = 15'h4001; pool[3] = 15'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", {58'd0, rsp_valid, rsp_ci, rsp_hit, rsp_miss_exc, rsp_fault_exc, 1'b0}, 64'd0);
      chk("R1", {rsp_paddr, rsp_exc_addr}, 64'd0);
      compare_on = 1'b1;

      // R1/R12: reset cleared valid bits, so address 0 misses
      xlat_en = 1'b1;
      lookup(32'h0, 0, 0, 0, 0);
      chk("R1", {63'd0, rsp_miss_exc}, 64'd1);

      // R3 bypass
      xlat_en = 1'b0;
      lookup(32'h1234_5678, 0, 0, 0, 0);
      chk("R3", {32'd0, rsp_paddr}, 64'h1234_5678);
      chk("R3", {63'd0, rsp_ci}, 64'd0);
      lookup(32'h8000_0000, 1, 0, 0, 0);
      chk("R3", {63'd0, rsp_ci}, 64'd1);
      lookup(32'h7FFF_FFFF, 0, 1, 0, 0);
      chk("R3", {63'd0, rsp_ci}, 64'd0);
      lookup(32'h9000_0000, 0, 0, 1, 0);
      chk("R11", {63'd0, rsp_ci}, 64'd0);

      // R5/R6 basic hit
      xlat_en = 1'b1;
      put(0, 3, 1'b0, (VA & TAGMASK) | 32'h1);
      put(0, 3, 1'b1, 32'h5554_2000 | 32'h1E);
      lookup(VA, 0, 0, 0, 0);
      chk("R5", {63'd0, rsp_hit}, 64'd1);
      chk("R6", {32'd0, rsp_paddr}, 64'h5554_2ABC);

      // R9 cache inhibit, R8 permissions
      put(0, 3, 1'b1, 32'h5554_2000 | 32'h03);
      lookup(VA, 0, 0, 0, 0);
      chk("R9", {63'd0, rsp_ci}, 64'd1);
      chk("R8", {63'd0, rsp_fault_exc}, 64'd0);
      lookup(VA, 1, 0, 0, 0);
      chk("R8", {63'd0, rsp_fault_exc}, 64'd1);
      chk("R8", {rsp_exc_addr, rsp_paddr}, {VA, 32'h5554_2ABC});
      lookup(VA, 0, 1, 0, 0);
      chk("R8", {63'd0, rsp_fault_exc}, 64'd1);
      put(0, 3, 1'b1, 32'h5554_2000 | 32'h18);
      lookup(VA, 1, 1, 0, 0);
      chk("R8", {63'd0, rsp_fault_exc}, 64'd0);
      lookup(VA, 0, 0, 0, 0);
      chk("R8", {63'd0, rsp_fault_exc}, 64'd1);
      put(0, 3, 1'b1, 32'h5554_2000 | 32'h1E);

      // R7 first matching way wins
      put(1, 3, 1'b0, (VA & TAGMASK) | 32'h1);
      put(1, 3, 1'b1, 32'h0ABC_0000 | 32'h1E);
      lookup(VA, 0, 0, 0, 0);
      chk("R7", {32'd0, rsp_paddr}, 64'h5554_2ABC);
      // R12 invalid way 0 no longer hits
      put(0, 3, 1'b0, (VA & TAGMASK));
      lookup(VA, 0, 0, 0, 0);
      chk("R12", {32'd0, rsp_paddr}, 64'h0ABC_0ABC);

      // R4 same tag, neighbouring set index misses
      lookup(VA + 32'h2000, 0, 0, 0, 0);
      chk("R4", {63'd0, rsp_miss_exc}, 64'd1);
      chk("R10", {rsp_exc_addr, rsp_paddr}, {VA + 32'h2000, 32'h0});

      // R11 probes
      lookup(VA + 32'h2000, 0, 0, 1, 1);
      chk("R11", {62'd0, rsp_miss_exc, rsp_fault_exc}, 64'd0);
      chk("R11", {32'd0, rsp_paddr}, 64'd0);
      xlat_en = 1'b0;
      lookup(32'h0, 0, 0, 0, 0);
      xlat_en = 1'b1;
      put(1, 3, 1'b1, 32'h0ABC_0000 | 32'h01);
      lookup(VA, 0, 0, 1, 1);
      chk("R11", {61'd0, rsp_ci, rsp_fault_exc, rsp_miss_exc}, 64'd0);
      chk("R11", {32'd0, rsp_paddr}, 64'd0);
      put(1, 3, 1'b1, 32'h0ABC_0000 | 32'h03);
      lookup(VA, 0, 0, 1, 0);
      chk("R11", {63'd0, rsp_ci}, 64'd0);
      chk("R11", {32'd0, rsp_paddr}, 64'h0ABC_0ABC);
      lookup(VA, 0, 0, 1, 1);
      chk("R11", {63'd0, rsp_ci}, 64'd1);

      // R2 strobe lasts one cycle
      req_valid = 1'b1; req_addr = VA; req_probe = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", {63'd0, rsp_valid}, 64'd1);
      @(negedge clk);
      chk("R2", {63'd0, rsp_valid}, 64'd0);

      // randomized traffic compared by the model every cycle
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] r;
         r = $urandom;
         req_valid   = r[0] | r[1];
         req_addr    = {pool[r[3:2]], 4'($urandom_range(0, 15)), 13'($urandom)};
         if (r[4] && r[5]) req_addr[31] = 1'b1;
         req_write   = r[6];
         req_super   = r[7];
         req_probe   = r[8] & r[9];
         req_thru_dc = r[10];
         if (r[15:11] == 5'd0) xlat_en = ~xlat_en;
         wr_en   = r[16] & r[17];
         wr_way  = r[19:18];
         wr_sel  = r[20];
         wr_set  = r[24:21];
         wr_data = r[20] ? $urandom
                         : {pool[r[26:25]], 16'($urandom), r[27] | r[28]};
         @(negedge clk);
      end
      req_valid = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule